// File: doc/BRIEF.md
# Synchronized Pulse Edge Accumulator

This block counts transitions on one asynchronous input pin and keeps the running total in a 16-bit register. The pin first passes through a two-flop synchronizer clocked by the bus clock. A registered edge detector then compares each synchronized sample with the one before it. A 2-bit control input chooses which transitions count: rising, falling or both. A separate enable input lets counting be paused.

Software reaches the count through a small register port with a 16-bit data path and two byte-lane enables. A word read takes both halves of the count in the same clock cycle. Two single-byte reads each sample the count in their own cycle, so they can disagree if an edge lands between them. A write loads any enabled lane of the count directly, and a write wins over an edge counted in the same cycle.

When the count wraps from its maximum to zero, a sticky overflow flag is set. Software clears the flag by writing a one to it. Because of the synchronizer, a transition appears in the count only a few clocks after it happens on the pin.

Top module: `edge_accum_top`

## Requirements
- R1: After reset the count is 0x0000, the overflow flag is 0 and rd_valid is 0.
- R2: Each counted transition adds exactly one to the count.
- R3: A pin level that is stable across rising clock edge n is reflected in the count from edge n+2 on. A word read issued at edge n+2 still returns the old value, and a word read at edge n+3 returns the new one.
- R4: ctl_edge_sel selects which transitions count: 2'b00 none, 2'b01 rising only, 2'b10 falling only, 2'b11 both.
- R5: While ctl_enable is 0, no transition is counted, and transitions seen during that time are not counted later.
- R6: A write with bus_addr=0 and bus_be=2'b11 loads bus_wdata into the count. This works whether or not counting is enabled.
- R7: A write with bus_addr=0 loads only the enabled lanes: bus_be[0] loads bits 7:0 and bus_be[1] loads bits 15:8. A lane that is not enabled keeps its value.
- R8: When a count write (bus_addr=0) and a counted transition fall in the same cycle, the count takes the written value and the transition is lost. With bus_be=2'b00 the count is simply unchanged.
- R9: A counted transition at 0xFFFF takes the count to 0x0000 and sets the overflow flag, which then stays set.
- R10: A write with bus_addr=1 and bus_wdata[0]=1 clears the overflow flag. The same write with bus_wdata[0]=0 leaves the flag as it is.
- R11: If a wrap and a flag-clear write fall in the same cycle, the flag ends up set.
- R12: A read (bus_en=1, bus_wr=0, bus_addr=0) raises rd_valid in the next cycle, and rd_data holds the count as it stood in the cycle of the request. Lanes enabled in bus_be appear in their own bit positions, and lanes not enabled read as zero.
- R13: A read with bus_addr=1 returns the overflow flag in bit 0, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_async | input | 1 | Asynchronous pulse input |
| ctl_edge_sel | input | 2 | Selects which transitions count |
| ctl_enable | input | 1 | Counting enable |
| bus_en | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 1 | 0 selects the count, 1 selects the status |
| bus_be | input | 2 | Byte-lane enables |
| bus_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after the request |
| rd_data | output | 16 | Read data |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a software write to the count and a transition arriving from the synchronizer. The second is a wrap of the count and a write that clears the flag. The bench provokes both by toggling the pin and then issuing the write exactly two clock edges later, which is when the detector fires. It judges the outcome from a later word read and from the flag output: the written value must hold with no extra count, and the flag must remain set. A behavioural model built on a queue of pin history predicts every read and flag value and is compared on every cycle. Back-to-back reads around a toggle pin down the exact latency.

// File: rtl/edge_accum_pkg.sv
// Package: shared types and register selectors for the edge accumulator.
// Assumes a byte-lane organised register port with one address bit.
package edge_accum_pkg;
    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    localparam logic SEL_COUNT  = 1'b0;
    localparam logic SEL_STATUS = 1'b1;
endpackage

// File: rtl/edge_accum_sync.sv
// Module: multi-flop synchronizer that brings an asynchronous level into
// the clock domain. Assumes the input is a slow level (no pulse stretching).
module edge_accum_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    // Shift the sampled level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/edge_accum_detect.sv
// Module: compares the synchronized level with the previous sample and
// flags a transition chosen by the edge selector while enabled.
// Assumes the input is already synchronous to clk.
module edge_accum_detect
    import edge_accum_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      level,
    input  logic [1:0] edge_sel,
    input  logic      enable,
    output logic      hit
);
    logic      prev_q;
    logic      rise;
    logic      fall;
    edge_sel_e sel;

    // Hold the last synchronized sample, even while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    // Qualify the raw transitions with the selected polarity and enable.
    always_comb begin
        sel  = edge_sel_e'(edge_sel);
        rise = level & ~prev_q;
        fall = ~level & prev_q;
        unique case (sel)
            EDGE_RISE: hit = enable & rise;
            EDGE_FALL: hit = enable & fall;
            EDGE_BOTH: hit = enable & (rise | fall);
            default:   hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/edge_accum_counter.sv
// Module: counter with byte-lane load and a sticky wrap flag.
// Assumes a load beats an increment in the same cycle, and a wrap beats
// a clear of the flag in the same cycle.
module edge_accum_counter #(
    parameter int CNT_W = 16,
    localparam int LANES = CNT_W / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             load,
    input  logic [LANES-1:0] load_be,
    input  logic [CNT_W-1:0] load_data,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic             wrap_flag
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] merged;
    logic             wrap;
    logic             flag_q;

    // Per-lane choice between written byte and held byte.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign merged[l*8 +: 8] = load_be[l] ? load_data[l*8 +: 8] : cnt_q[l*8 +: 8];
    end

    assign wrap = inc & ~load & (&cnt_q);

    // Count register: load first, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= merged;
        else if (inc)  cnt_q <= cnt_q + 1'b1;
    end

    // Sticky flag: set on wrap, cleared on request otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (wrap)     flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    assign count     = cnt_q;
    assign wrap_flag = flag_q;
endmodule

// File: rtl/edge_accum_top.sv
// Module: pulse edge accumulator top. Chains synchronizer, detector and
// counter and serves a registered read path that samples the whole
// count in one cycle. Assumes bus signals are synchronous to clk.
module edge_accum_top
    import edge_accum_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int SYNC_FLOPS = 2,
    localparam int LANES = CNT_W / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_async,
    input  logic [1:0]       ctl_edge_sel,
    input  logic             ctl_enable,
    input  logic             bus_en,
    input  logic             bus_wr,
    input  logic             bus_addr,
    input  logic [LANES-1:0] bus_be,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic             rd_valid,
    output logic [CNT_W-1:0] rd_data,
    output logic             ovf_flag
);
    logic             pin_sync;
    logic             edge_hit;
    logic             cnt_load;
    logic             flag_clr;
    logic             rd_req;
    logic [CNT_W-1:0] count_w;
    logic [CNT_W-1:0] lane_view;
    logic             rd_valid_q;
    logic [CNT_W-1:0] rd_data_q;

    edge_accum_sync #(.STAGES(SYNC_FLOPS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_async),
        .dout  (pin_sync)
    );

    edge_accum_detect u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (pin_sync),
        .edge_sel (ctl_edge_sel),
        .enable   (ctl_enable),
        .hit      (edge_hit)
    );

    assign cnt_load = bus_en & bus_wr & (bus_addr == SEL_COUNT);
    assign flag_clr = bus_en & bus_wr & (bus_addr == SEL_STATUS) & bus_wdata[0];
    assign rd_req   = bus_en & ~bus_wr;

    edge_accum_counter #(.CNT_W(CNT_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc       (edge_hit),
        .load      (cnt_load),
        .load_be   (bus_be),
        .load_data (bus_wdata),
        .flag_clr  (flag_clr),
        .count     (count_w),
        .wrap_flag (ovf_flag)
    );

    // Mask the count by the requested byte lanes.
    for (genvar l = 0; l < LANES; l++) begin : g_rdlane
        assign lane_view[l*8 +: 8] = bus_be[l] ? count_w[l*8 +: 8] : 8'h00;
    end

    // Capture read data in the request cycle so all lanes are coherent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= rd_req;
            if (rd_req)
                rd_data_q <= (bus_addr == SEL_STATUS) ? {{(CNT_W-1){1'b0}}, ovf_flag} : lane_view;
        end
    end

    assign rd_valid = rd_valid_q;
    assign rd_data  = rd_data_q;
endmodule

// File: rtl/edge_accum_checker.sv
// Module: property checker for the edge accumulator, bound to the top.
// Assumes it sees the internal count through the bind connection.
module edge_accum_checker #(
    parameter int CNT_W = 16,
    localparam int LANES = CNT_W / 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_en,
    input logic             bus_wr,
    input logic             bus_addr,
    input logic [LANES-1:0] bus_be,
    input logic [CNT_W-1:0] bus_wdata,
    input logic             rd_valid,
    input logic [CNT_W-1:0] rd_data,
    input logic             ovf_flag,
    input logic [CNT_W-1:0] count_w
);
    // R2: without a load, the count only ever moves up by one.
    p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (count_w != $past(count_w)) && !$past(bus_en && bus_wr && !bus_addr)
        |-> count_w == $past(count_w) + 1'b1);

    // R8: a full-word load always lands, whatever the detector did.
    p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_en && bus_wr && !bus_addr && (&bus_be)) |-> count_w == $past(bus_wdata));

    // R9: a wrap without load leaves the flag set.
    p_wrap_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(&count_w) && count_w == '0 && !$past(bus_en && bus_wr && !bus_addr))
        |-> ovf_flag);

    // R10: the flag falls only after a clear write.
    p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf_flag) |-> $past(bus_en && bus_wr && bus_addr && bus_wdata[0]));

    // R12: read data is valid only one cycle after a read request.
    p_rd_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid == $past(bus_en && !bus_wr));

    // R13: a status read shows the flag of the request cycle.
    p_status_read_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(bus_addr)) |-> rd_data == {{(CNT_W-1){1'b0}}, $past(ovf_flag)});
endmodule

bind edge_accum_top edge_accum_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .ovf_flag  (ovf_flag),
    .count_w   (count_w)
);

// File: tb/edge_accum_top_bench.sv
module edge_accum_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_async = 1'b0;
    logic [1:0]  ctl_edge_sel = 2'b11;
    logic        ctl_enable = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_addr = 1'b0;
    logic [1:0]  bus_be = 2'b00;
    logic [15:0] bus_wdata = 16'h0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        ovf_flag;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    edge_accum_top u_edge_accum_top (
        .clk(clk), .rst_n(rst_n), .pin_async(pin_async),
        .ctl_edge_sel(ctl_edge_sel), .ctl_enable(ctl_enable),
        .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .ovf_flag(ovf_flag)
    );

    // Behavioural reference model.
    int          pin_hist[$];
    int unsigned m_count = 0;
    bit          m_ovf = 0;
    bit          m_rv = 0;
    int unsigned m_rd = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            pin_hist = {0, 0, 0};
            m_count = 0; m_ovf = 0; m_rv = 0; m_rd = 0;
        end else begin
            int  now_lvl, old_lvl;
            bit  counted, wrapped;
            now_lvl = pin_hist[1];
            old_lvl = pin_hist[0];
            counted = ctl_enable && (
                (ctl_edge_sel[0] && now_lvl == 1 && old_lvl == 0) ||
                (ctl_edge_sel[1] && now_lvl == 0 && old_lvl == 1));
            m_rv = bus_en && !bus_wr;
            if (m_rv) begin
                if (bus_addr) m_rd = m_ovf;
                else m_rd = (bus_be[0] ? (m_count & 'hFF) : 0) + (bus_be[1] ? (m_count & 'hFF00) : 0);
            end
            wrapped = 0;
            if (bus_en && bus_wr && !bus_addr) begin
                if (bus_be[0]) m_count = (m_count & 'hFF00) | (bus_wdata & 'hFF);
                if (bus_be[1]) m_count = (m_count & 'hFF) | (bus_wdata & 'hFF00);
            end else if (counted) begin
                wrapped = (m_count == 'hFFFF);
                m_count = (m_count + 1) % 65536;
            end
            if (wrapped) m_ovf = 1;
            else if (bus_en && bus_wr && bus_addr && bus_wdata[0]) m_ovf = 0;
            pin_hist.push_back(int'(pin_async));
            void'(pin_hist.pop_front());
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    // Per-cycle comparison against the model (R12, R13, R9).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R12 model rd_valid", int'(rd_valid), int'(m_rv));
            if (rd_valid) chk("R12 model rd_data", int'(rd_data), int'(m_rd));
            chk("R9 model ovf_flag", int'(ovf_flag), int'(m_ovf));
        end
    end

    task automatic bus_op(input bit wr, input bit addr, input logic [1:0] be, input logic [15:0] wd);
        bus_en = 1; bus_wr = wr; bus_addr = addr; bus_be = be; bus_wdata = wd;
        @(negedge clk);
        bus_en = 0; bus_wr = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_word(output logic [15:0] v);
        bus_op(0, 0, 2'b11, 16'h0);
        v = rd_data;
    endtask

    task automatic toggle_settle();
        pin_async = ~pin_async;
        idle(4);
    endtask

    task automatic finish_run();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [15:0] v;
        logic [15:0] cap[4];
        idle(3);
        chk("R1 rd_valid in reset", int'(rd_valid), 0);
        rst_n = 1;
        idle(1);
        chk("R1 ovf after reset", int'(ovf_flag), 0);
        read_word(v);
        chk("R1 count after reset", v, 16'h0000);

        ctl_enable = 1; ctl_edge_sel = 2'b01;
        toggle_settle();
        read_word(v);
        chk("R2 one rising edge", v, 16'h0001);
        toggle_settle();
        read_word(v);
        chk("R4 falling ignored in rise mode", v, 16'h0001);

        ctl_edge_sel = 2'b10;
        toggle_settle(); toggle_settle();
        read_word(v);
        chk("R4 fall mode counts one of two", v, 16'h0002);
        ctl_edge_sel = 2'b11;
        toggle_settle(); toggle_settle();
        read_word(v);
        chk("R4 both mode counts two", v, 16'h0004);
        ctl_edge_sel = 2'b00;
        toggle_settle(); toggle_settle();
        read_word(v);
        chk("R4 none mode counts zero", v, 16'h0004);

        // R3 latency with back-to-back word reads.
        ctl_edge_sel = 2'b11;
        pin_async = ~pin_async;
        bus_en = 1; bus_wr = 0; bus_addr = 0; bus_be = 2'b11;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            cap[i] = rd_data;
        end
        bus_en = 0;
        chk("R3 read at edge n+2 still old", cap[2], 16'h0004);
        chk("R3 read at edge n+3 updated", cap[3], 16'h0005);
        idle(3);

        ctl_enable = 0;
        toggle_settle(); toggle_settle(); toggle_settle();
        ctl_enable = 1;
        idle(3);
        read_word(v);
        chk("R5 disabled edges not counted", v, 16'h0005);

        ctl_enable = 0;
        bus_op(1, 0, 2'b11, 16'h1234);
        read_word(v);
        chk("R6 word write while disabled", v, 16'h1234);
        ctl_enable = 1;
        bus_op(1, 0, 2'b01, 16'hEE56);
        read_word(v);
        chk("R7 low lane write", v, 16'h1256);
        bus_op(1, 0, 2'b10, 16'hAB77);
        read_word(v);
        chk("R7 high lane write", v, 16'hAB56);

        bus_op(0, 0, 2'b01, 16'h0);
        chk("R12 low lane read", int'(rd_data), 16'h0056);
        bus_op(0, 0, 2'b10, 16'h0);
        chk("R12 high lane read", int'(rd_data), 16'hAB00);

        // R8: write lands in the same cycle as a counted edge.
        bus_op(1, 0, 2'b11, 16'h0010);
        idle(2);
        pin_async = ~pin_async;
        idle(2);
        bus_op(1, 0, 2'b11, 16'h0100);
        idle(3);
        read_word(v);
        chk("R8 write beats edge", v, 16'h0100);

        bus_op(1, 0, 2'b11, 16'hFFFF);
        toggle_settle();
        read_word(v);
        chk("R9 wrap to zero", v, 16'h0000);
        chk("R9 flag set on wrap", int'(ovf_flag), 1);
        bus_op(0, 1, 2'b11, 16'h0);
        chk("R13 status read shows flag", int'(rd_data), 16'h0001);
        bus_op(1, 1, 2'b11, 16'hFFFE);
        chk("R10 write of zero keeps flag", int'(ovf_flag), 1);

        // R11: wrap and clear in the same cycle.
        bus_op(1, 0, 2'b11, 16'hFFFF);
        idle(2);
        pin_async = ~pin_async;
        idle(2);
        bus_op(1, 1, 2'b11, 16'h0001);
        chk("R11 wrap beats clear", int'(ovf_flag), 1);
        idle(2);
        bus_op(1, 1, 2'b11, 16'h0001);
        chk("R10 clear write", int'(ovf_flag), 0);
        bus_op(0, 1, 2'b11, 16'h0);
        chk("R13 status read after clear", int'(rd_data), 16'h0000);
        idle(3);
        finish_run();
    end
endmodule